// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-visible register file of an asynchronous serial port that has a receive FIFO. A processor reaches it over a simple bus that completes each access in one cycle. Register offsets are byte addresses spaced four apart. The block holds the mode, bit-rate, control, FIFO-control and port registers. It also keeps a status register of sticky flags. A flag is cleared only when software writes a zero to its bit. Writing a one to a flag bit leaves it unchanged.

Writing the transmit data offset sends the byte out on a one-cycle byte stream and marks the transmit data register as no longer empty. Some accesses have side effects on the flags and on the two interrupt request lines, and several of these happen in the same cycle as the access.

The receive FIFO storage lives in a separate block. That block reports its fill count, the byte at its head, a trigger-reached pulse and a timeout pulse. This block returns the head byte to software and asks the FIFO to pop it. It also requests a FIFO flush and passes the decoded trigger level to the FIFO. Bit-rate generation and serialization are outside this block.

Top module: `sci_regs`

## Requirements
- R1: After reset, reads return 0x00 for mode (offset 0x00), 0xFF for bit rate (0x04), 0x20 for control (0x08), 0x00 for FIFO control (0x18), 0x00 for port (0x20) and 0x60 for status (0x10). Both interrupt lines are low and the trigger level output is 1.
- R2: Writes are masked before storage. Mode keeps the bits of 0x7B, control keeps 0xFA and port keeps 0xF3. Bit rate and FIFO control store all 8 bits.
- R3: Status bits are: bit 6 transmit end, bit 5 transmit data empty, bit 4 break, bit 1 receive trigger reached, bit 0 data ready. All other bits read 0. A status write clears each of these flags whose written bit is 0 and leaves unchanged each flag whose written bit is 1.
- R4: A status read while control bit 5 (transmit enable) is 1 returns the flags as they were, then sets transmit end and transmit data empty. With control bit 5 at 0, a status read changes no flag.
- R5: A write to offset 0x0C makes tx_valid high for the following cycle with tx_byte equal to the written byte, and clears transmit data empty.
- R6: A control write whose bit 5 is 0 sets transmit end. irq_tx follows control bit 7 from the cycle after the write.
- R7: irq_rx goes high on the cycle after a rx_trig_hit or rx_timeout pulse if control bit 6 is 1, and stays low otherwise. It drops after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. A set in the same cycle wins over a clear.
- R8: A rx_trig_hit pulse sets status bit 1 and a rx_timeout pulse sets status bit 0. Each set wins over a clear in the same cycle.
- R9: A one-cycle brk_pulse sets status bit 4.
- R10: A FIFO-control write with bit 1 at 1 gives a one-cycle fifo_clear pulse on the next cycle and clears status bit 1. FIFO-control bits 7:6 choose a trigger level of 1, 4, 8 or 14, driven on rx_level.
- R11: A read of offset 0x14 with rx_count non-zero returns rx_data and raises rx_pop during that cycle. If rx_count minus one is then below the trigger level, status bit 1 clears. With rx_count at zero, the read returns 0 and does not pop.
- R12: A read of offset 0x1C returns rx_count. Reads of 0x24 and of unmapped offsets return 0. Writes to 0x14, 0x1C and 0x24 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| brk_pulse | input | 1 | Break detected |
| rx_trig_hit | input | 1 | FIFO fill reached the trigger level |
| rx_timeout | input | 1 | Receive idle timeout |
| rx_count | input | 5 | FIFO fill count |
| rx_data | input | 8 | Byte at FIFO head |
| rx_pop | output | 1 | Pop the FIFO head |
| fifo_clear | output | 1 | Flush the FIFO |
| rx_level | output | 5 | Decoded trigger level |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The hardest behaviour to reach from the ports is the status read side effect, because the value a read returns differs from the flag state it leaves behind. The stimulus first clears the transmit flags with a zero write. It then reads twice with transmit enable on and twice with it off, so both the captured value and the re-set state are seen. The conditional clear of the trigger flag on a pop is reached by holding rx_count just above, and then exactly at, the trigger level.

// File: rtl/sci_regs.sv
module sci_regs #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  input  logic          brk_pulse,
  input  logic          rx_trig_hit,
  input  logic          rx_timeout,
  input  logic [CW-1:0] rx_count,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pop,
  output logic          fifo_clear,
  output logic [CW-1:0] rx_level,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam logic [AW-1:0] A_MODE = AW'(8'h00);
  localparam logic [AW-1:0] A_BAUD = AW'(8'h04);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] A_TXD  = AW'(8'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_RXD  = AW'(8'h14);
  localparam logic [AW-1:0] A_FCTL = AW'(8'h18);
  localparam logic [AW-1:0] A_RCNT = AW'(8'h1C);
  localparam logic [AW-1:0] A_PORT = AW'(8'h20);
  localparam logic [DW-1:0] M_MODE = DW'(8'h7B);
  localparam logic [DW-1:0] M_CTRL = DW'(8'hFA);
  localparam logic [DW-1:0] M_PORT = DW'(8'hF3);

  logic [DW-1:0] mode_q, baud_q, ctrl_q, fctl_q, port_q;
  logic st_tend, st_tde, st_brk, st_rdf, st_dr;

  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  logic wr_ctrl, wr_txd, wr_stat, wr_fctl, rd_stat;
  assign wr_ctrl = wr && bus_addr == A_CTRL;
  assign wr_txd  = wr && bus_addr == A_TXD;
  assign wr_stat = wr && bus_addr == A_STAT;
  assign wr_fctl = wr && bus_addr == A_FCTL;
  assign rd_stat = rd && bus_addr == A_STAT;

  assign rx_pop = rd && bus_addr == A_RXD && rx_count != '0;

  always_comb begin
    unique case (fctl_q[7:6])
      2'd0: rx_level = CW'(1);
      2'd1: rx_level = CW'(4);
      2'd2: rx_level = CW'(8);
      default: rx_level = CW'(14);
    endcase
  end

  logic pop_below;
  assign pop_below = rx_pop && ((rx_count - CW'(1)) < rx_level);

  logic tx_rearm;
  assign tx_rearm = rd_stat & ctrl_q[5];

  logic [DW-1:0] stat_view;
  assign stat_view = DW'({1'b0, st_tend, st_tde, st_brk, 2'b00, st_rdf, st_dr});

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        A_MODE: bus_rdata = mode_q;
        A_BAUD: bus_rdata = baud_q;
        A_CTRL: bus_rdata = ctrl_q;
        A_STAT: bus_rdata = stat_view;
        A_RXD:  bus_rdata = (rx_count != '0) ? rx_data : '0;
        A_FCTL: bus_rdata = fctl_q;
        A_RCNT: bus_rdata = DW'(rx_count);
        A_PORT: bus_rdata = port_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      baud_q <= '1;
      ctrl_q <= DW'(8'h20);
      fctl_q <= '0;
      port_q <= '0;
    end else if (wr) begin
      unique case (bus_addr)
        A_MODE: mode_q <= bus_wdata & M_MODE;
        A_BAUD: baud_q <= bus_wdata;
        A_CTRL: ctrl_q <= bus_wdata & M_CTRL;
        A_FCTL: fctl_q <= bus_wdata;
        A_PORT: port_q <= bus_wdata & M_PORT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= wr_txd;
      if (wr_txd) tx_byte <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_tend <= 1'b1;
      st_tde  <= 1'b1;
    end else if (tx_rearm) begin
      st_tend <= 1'b1;
      st_tde  <= 1'b1;
    end else begin
      if (wr_ctrl && !bus_wdata[5])      st_tend <= 1'b1;
      else if (wr_stat && !bus_wdata[6]) st_tend <= 1'b0;
      if (wr_txd || (wr_stat && !bus_wdata[5])) st_tde <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_brk <= 1'b0;
      st_rdf <= 1'b0;
      st_dr  <= 1'b0;
    end else begin
      if (brk_pulse)                     st_brk <= 1'b1;
      else if (wr_stat && !bus_wdata[4]) st_brk <= 1'b0;
      if (rx_trig_hit) st_rdf <= 1'b1;
      else if ((wr_stat && !bus_wdata[1]) || (wr_fctl && bus_wdata[1]) || pop_below)
        st_rdf <= 1'b0;
      if (rx_timeout)                    st_dr <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) st_dr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_rx     <= 1'b0;
      fifo_clear <= 1'b0;
    end else begin
      fifo_clear <= wr_fctl & bus_wdata[1];
      if ((rx_trig_hit || rx_timeout) && ctrl_q[6]) irq_rx <= 1'b1;
      else if ((wr_ctrl && !bus_wdata[6]) || (wr_stat && (!bus_wdata[1] || !bus_wdata[0])))
        irq_rx <= 1'b0;
    end
  end

  assign irq_tx = ctrl_q[7];
endmodule

// File: rtl/sci_regs_chk.sv
module sci_regs_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tx_valid,
  input logic [DW-1:0] tx_byte,
  input logic          irq_rx,
  input logic          irq_tx,
  input logic          rx_trig_hit,
  input logic          rx_timeout,
  input logic          brk_pulse,
  input logic          fifo_clear,
  input logic          st_tde,
  input logic          st_rdf,
  input logic          st_brk
);
  logic wr;
  assign wr = bus_en & bus_we;

  assert_tx_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(8'h0C)) |=> (tx_valid && tx_byte == $past(bus_wdata) && !st_tde));

  assert_tx_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(8'h08)) |=> (irq_tx == $past(bus_wdata[7])));

  assert_rx_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(8'h08) && !bus_wdata[6] && !rx_trig_hit && !rx_timeout) |=> !irq_rx);

  assert_brk_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> st_brk);

  assert_fifo_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(8'h18) && bus_wdata[1] && !rx_trig_hit) |=> (fifo_clear && !st_rdf));

  assert_tde_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == AW'(8'h10) && !bus_wdata[5]) |=> !st_tde);
endmodule

bind sci_regs sci_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
  .tx_byte(tx_byte), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout), .brk_pulse(brk_pulse),
  .fifo_clear(fifo_clear), .st_tde(st_tde), .st_rdf(st_rdf), .st_brk(st_brk)
);

// File: tb/sci_regs_tb.sv
module sci_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tx_valid;
  logic [7:0] tx_byte;
  logic brk_pulse = 1'b0, rx_trig_hit = 1'b0, rx_timeout = 1'b0;
  logic [4:0] rx_count = '0;
  logic [7:0] rx_data = '0;
  logic rx_pop, fifo_clear, irq_rx, irq_tx;
  logic [4:0] rx_level;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sci_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .brk_pulse(brk_pulse),
    .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout), .rx_count(rx_count),
    .rx_data(rx_data), .rx_pop(rx_pop), .fifo_clear(fifo_clear),
    .rx_level(rx_level), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // {write, offset, data, expected read}
  localparam logic [24:0] VEC [16] = '{
    {1'b1, 8'h00, 8'hFF, 8'h00}, {1'b0, 8'h00, 8'h00, 8'h7B},
    {1'b1, 8'h04, 8'hA5, 8'h00}, {1'b0, 8'h04, 8'h00, 8'hA5},
    {1'b1, 8'h20, 8'hFF, 8'h00}, {1'b0, 8'h20, 8'h00, 8'hF3},
    {1'b1, 8'h18, 8'hC0, 8'h00}, {1'b0, 8'h18, 8'h00, 8'hC0},
    {1'b1, 8'h08, 8'hFF, 8'h00}, {1'b0, 8'h08, 8'h00, 8'hFA},
    {1'b1, 8'h14, 8'h55, 8'h00}, {1'b0, 8'h14, 8'h00, 8'h00},
    {1'b1, 8'h1C, 8'h33, 8'h00}, {1'b0, 8'h1C, 8'h00, 8'h00},
    {1'b0, 8'h24, 8'h00, 8'h00}, {1'b0, 8'h3C, 8'h00, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic pop);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[5:0];
    #2;
    v = bus_rdata;
    pop = rx_pop;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    logic p;
    rd(a, v, p);
    check(req, int'(v), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic p;
    do_reset();

    // table: R2 masks, R11 empty read, R12 read-only and unmapped offsets
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
      else rdchk($sformatf("R2 R11 R12 vector %0d", i), VEC[i][23:16], VEC[i][7:0]);
    end

    do_reset();
    // R1
    rdchk("R1 mode", 8'h00, 8'h00);
    rdchk("R1 baud", 8'h04, 8'hFF);
    rdchk("R1 ctrl", 8'h08, 8'h20);
    rdchk("R1 fctl", 8'h18, 8'h00);
    rdchk("R1 port", 8'h20, 8'h00);
    rdchk("R1 status", 8'h10, 8'h60);
    check("R1 irq_tx", int'(irq_tx), 0);
    check("R1 irq_rx", int'(irq_rx), 0);
    check("R1 level", int'(rx_level), 1);

    // R5
    wr(8'h0C, 8'h41);
    check("R5 tx_valid", int'(tx_valid), 1);
    check("R5 tx_byte", int'(tx_byte), 8'h41);
    rdchk("R5 tde cleared", 8'h10, 8'h40);
    rdchk("R4 rearm after read", 8'h10, 8'h60);
    check("R5 tx_valid one cycle", int'(tx_valid), 0);

    // R3 and R4
    wr(8'h10, 8'h00);
    rdchk("R4 value before rearm", 8'h10, 8'h00);
    rdchk("R4 rearmed", 8'h10, 8'h60);
    wr(8'h10, 8'hFF);
    rdchk("R3 ones keep", 8'h10, 8'h60);
    wr(8'h08, 8'h00);
    wr(8'h10, 8'h00);
    rdchk("R3 zero clears", 8'h10, 8'h00);
    rdchk("R4 no rearm when disabled", 8'h10, 8'h00);
    wr(8'h08, 8'h00);
    rdchk("R6 tend set", 8'h10, 8'h40);

    // R9
    @(negedge clk); brk_pulse = 1'b1;
    @(negedge clk); brk_pulse = 1'b0;
    rdchk("R9 break", 8'h10, 8'h50);
    wr(8'h10, 8'hEF);
    rdchk("R3 break cleared alone", 8'h10, 8'h40);

    // R7 and R8
    wr(8'h08, 8'h40);
    @(negedge clk); rx_trig_hit = 1'b1;
    @(negedge clk); rx_trig_hit = 1'b0;
    check("R7 irq on trigger", int'(irq_rx), 1);
    rdchk("R8 trigger flag", 8'h10, 8'h42);
    wr(8'h10, 8'hFD);
    check("R7 irq drop on status", int'(irq_rx), 0);
    rdchk("R3 trigger cleared", 8'h10, 8'h40);
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
    check("R7 irq on timeout", int'(irq_rx), 1);
    rdchk("R8 data ready", 8'h10, 8'h41);
    wr(8'h08, 8'h00);
    check("R7 irq drop on control", int'(irq_rx), 0);
    @(negedge clk); rx_trig_hit = 1'b1;
    @(negedge clk); rx_trig_hit = 1'b0;
    check("R7 no irq when disabled", int'(irq_rx), 0);
    rdchk("R8 flag without irq", 8'h10, 8'h43);

    // R6
    wr(8'h08, 8'h80);
    check("R6 irq_tx high", int'(irq_tx), 1);
    wr(8'h08, 8'h00);
    check("R6 irq_tx low", int'(irq_tx), 0);

    // R10
    wr(8'h18, 8'h42);
    check("R10 fifo_clear", int'(fifo_clear), 1);
    check("R10 level 4", int'(rx_level), 4);
    rdchk("R10 trigger flag cleared", 8'h10, 8'h41);
    wr(8'h18, 8'h80);
    check("R10 fifo_clear one cycle", int'(fifo_clear), 0);
    check("R10 level 8", int'(rx_level), 8);
    wr(8'h18, 8'hC0);
    check("R10 level 14", int'(rx_level), 14);
    wr(8'h18, 8'h00);
    check("R10 level 1", int'(rx_level), 1);

    // R11
    wr(8'h18, 8'h40);
    rx_count = 5'd5; rx_data = 8'h9A;
    @(negedge clk); rx_trig_hit = 1'b1;
    @(negedge clk); rx_trig_hit = 1'b0;
    rd(8'h14, v, p);
    check("R11 data", int'(v), 8'h9A);
    check("R11 pop", int'(p), 1);
    rdchk("R11 flag kept at level", 8'h10, 8'h43);
    rx_count = 5'd4;
    rd(8'h14, v, p);
    check("R11 pop below", int'(p), 1);
    rdchk("R11 flag cleared below level", 8'h10, 8'h41);
    rx_count = 5'd0;
    rd(8'h14, v, p);
    check("R11 empty data", int'(v), 0);
    check("R11 empty no pop", int'(p), 0);

    // R12
    rx_count = 5'd7;
    rdchk("R12 count", 8'h1C, 8'h07);
    wr(8'h24, 8'hFF);
    rdchk("R12 line status", 8'h24, 8'h00);
    rx_count = 5'd3;
    wr(8'h14, 8'h55);
    rdchk("R12 rx data write ignored", 8'h14, 8'h9A);
    rdchk("R12 other regs untouched", 8'h04, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule